// File: doc/BRIEF.md
# Security Code Gate with Attempt Counter

This block guards write access to a card memory behind a secret code. It keeps a small security store: slot 0 is a 3-bit attempt counter, and slots 1 to 3 hold the secret code bytes. Decoded commands from the interface logic arrive one at a time. There are two kinds: an update of a security slot, and a compare of one code byte. The block decides whether each command may act, keeps the processing line busy for the command's duration, and raises a failure strobe when a command is refused or a compare misses. Its `wr_en` output grants write access to the memory update engine. A combinational read port returns a slot's contents, with the code bytes masked while the gate is locked.

A valid attempt has a fixed order. First, an update of slot 0 spends at least one remaining counter bit. Then three compares follow, for slots 1, 2 and 3 in that order, each with the matching byte. The gate opens when the third compare completes. It stays open until the power-on reset. Once open, every slot can be rewritten, including restoring spent counter bits. When no counter bit is left, no attempt can begin. In this register model, the reset reloads the shipped contents from parameters.

The sequence tracker has three states:
- `SQ_IDLE`: no attempt is in progress.
- `SQ_ARMED`: a counter bit has been spent and the first compare is expected.
- `SQ_PART`: some code bytes have matched, and `pos` names the next slot expected.

Its transitions take effect only when a command completes:
- **spend**: `SQ_IDLE`, `SQ_ARMED` or `SQ_PART` go to `SQ_ARMED`.
- **match**: `SQ_ARMED` goes to `SQ_PART`, or `SQ_PART` advances `pos`.
- **open**: from `SQ_PART` on the last slot, the gate opens and the tracker returns to `SQ_IDLE`.
- **miss**: any state goes to `SQ_IDLE`.
- **break**: any state goes to `SQ_IDLE` at once.

The processing timer has two states. `PR_IDLE` goes to `PR_RUN` on **accept**. `PR_RUN` goes back to `PR_IDLE` on **finish** or **break**.

Top module: `sec_unlock`

## Requirements
- R1: After reset, slot 0 reads 0x07 (all three counter bits set), `wr_en` is 0 and `busy` is 0.
- R2: `rd_idx` selects a slot: 0 is the counter, with bits 7:3 always 0, and 1 to 3 are the code bytes. While `wr_en` is 0, code slots read 0x00. Once `wr_en` is 1, they read their stored values.
- R3: `cmd_op` 0 is an update. While locked, an update of slot 0 that clears at least one set counter bit stores `counter & cmd_data[2:0]`, holds `busy` for 6 cycles, and arms the sequence.
- R4: While locked, an update of slots 1 to 3, or an update of slot 0 that clears no counter bit, is refused. The store is unchanged, `busy` lasts 2 cycles, and `fail` is high in the last busy cycle.
- R5: `cmd_op` 1 is a compare. Every compare holds `busy` for exactly 2 cycles.
- R6: When the sequence is armed, matching compares of slots 1, 2 and 3 in that order set `wr_en` at the end of the third compare.
- R7: A compare that misses, arrives out of slot order, or is not preceded by a spend raises `fail` and voids the attempt. Later matching compares do not open the gate without a new spend.
- R8: Once the counter is 0, every update of slot 0 is refused while locked, so `wr_en` stays 0.
- R9: While unlocked, an update writes any slot. Slot 0 takes `cmd_data[2:0]`, so 0xFF restores the counter to 0x07. Code slots take the full byte.
- R10: `brk` ends any command within one cycle and discards the command's pending tracker change, resetting the tracker. It never clears an open gate.
- R11: `cmd_valid` is ignored while `busy` is 1.
- R12: While locked, no counter bit ever goes from 0 to 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low power-on reset; closes the gate and reloads the store |
| brk | input | 1 | Abort of the current command |
| cmd_valid | input | 1 | A decoded command is presented |
| cmd_op | input | 1 | 0 = update, 1 = compare |
| cmd_addr | input | 2 | Security slot addressed |
| cmd_data | input | 8 | Write data or compare byte |
| rd_idx | input | 2 | Slot selected for reading |
| rd_data | output | 8 | Masked contents of the selected slot |
| busy | output | 1 | Command processing in progress |
| wr_en | output | 1 | Write access to the memory is granted |
| fail | output | 1 | Current command is refused or missed (last busy cycle) |

## Verification
Some properties are checked by assertions on every cycle:
- the masking of code slots while locked, and the always-zero upper counter bits;
- the counter never regaining bits while locked;
- the gate staying open once opened, and opening only at the end of a busy period;
- the store holding still while busy, and `fail` appearing only inside a busy period;
- every busy period ending within 8 cycles.

Other behaviour needs the bench's scenarios and its cycle-by-cycle model:
- the exact busy lengths and when `fail` appears;
- the strict compare order;
- voiding an attempt by a miss or by a break;
- exhausting the counter;
- rewriting the code bytes after opening.

// File: rtl/sec_unlock_pkg.sv
package sec_unlock_pkg;

    typedef enum logic [1:0] {
        SQ_IDLE  = 2'd0,
        SQ_ARMED = 2'd1,
        SQ_PART  = 2'd2
    } seq_e;

    typedef enum logic {
        PR_IDLE = 1'b0,
        PR_RUN  = 1'b1
    } proc_e;

    localparam logic OP_UPDATE  = 1'b0;
    localparam logic OP_COMPARE = 1'b1;

endpackage

// File: rtl/sec_store.sv
module sec_store #(
    parameter int DATA_W     = 8,
    parameter int CODE_BYTES = 3,
    parameter int EC_BITS    = 3,
    parameter int AW         = 2,
    parameter logic [EC_BITS-1:0] INIT_EC = '1,
    parameter logic [CODE_BYTES*DATA_W-1:0] INIT_CODE = '0
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         wr_stb,
    input  logic [AW-1:0]                wr_addr,
    input  logic [DATA_W-1:0]            wr_data,
    input  logic                         unlocked,
    input  logic [AW-1:0]                rd_idx,
    output logic [DATA_W-1:0]            rd_data,
    output logic [EC_BITS-1:0]           ec_o,
    output logic [CODE_BYTES*DATA_W-1:0] code_o
);

    logic [EC_BITS-1:0] ec_q;

    // Attempt counter slot
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ec_q <= INIT_EC;
        end else if (wr_stb && wr_addr == '0) begin
            ec_q <= wr_data[EC_BITS-1:0];
        end
    end

    assign ec_o = ec_q;

    // Code byte slots, one register per slot
    for (genvar g = 1; g <= CODE_BYTES; g++) begin : g_code
        logic [DATA_W-1:0] byte_q;

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                byte_q <= INIT_CODE[(g-1)*DATA_W +: DATA_W];
            end else if (wr_stb && wr_addr == AW'(g)) begin
                byte_q <= wr_data;
            end
        end

        assign code_o[(g-1)*DATA_W +: DATA_W] = byte_q;
    end

    // Read mux: code slots are masked while the gate is locked
    always_comb begin
        rd_data = '0;
        if (rd_idx == '0) begin
            rd_data[EC_BITS-1:0] = ec_q;
        end else if (unlocked) begin
            for (int k = 1; k <= CODE_BYTES; k++) begin
                if (rd_idx == AW'(k)) begin
                    rd_data = code_o[(k-1)*DATA_W +: DATA_W];
                end
            end
        end
    end

endmodule

// File: rtl/sec_judge.sv
module sec_judge
    import sec_unlock_pkg::*;
#(
    parameter int DATA_W     = 8,
    parameter int CODE_BYTES = 3,
    parameter int EC_BITS    = 3,
    parameter int AW         = 2,
    parameter int LW         = 3,
    parameter int UPD_CYCLES = 6,
    parameter int CMP_CYCLES = 2,
    parameter int REJ_CYCLES = 2
) (
    input  logic                         op,
    input  logic [AW-1:0]                addr,
    input  logic [DATA_W-1:0]            data,
    input  logic [EC_BITS-1:0]           ec,
    input  logic [CODE_BYTES*DATA_W-1:0] code,
    input  seq_e                         seq,
    input  logic [AW-1:0]                pos,
    input  logic                         unlocked,
    output logic                         wr_stb,
    output logic [DATA_W-1:0]            wr_data,
    output logic                         v_fail,
    output seq_e                         v_state,
    output logic [AW-1:0]                v_pos,
    output logic                         v_unlock,
    output logic [LW-1:0]                run_len
);

    logic [DATA_W-1:0]  expect_byte;
    logic [EC_BITS-1:0] ec_spent;
    logic               spends_bit;
    logic               in_order;

    // Code byte the tracker expects next
    always_comb begin
        expect_byte = '0;
        for (int k = 1; k <= CODE_BYTES; k++) begin
            if (pos == AW'(k)) begin
                expect_byte = code[(k-1)*DATA_W +: DATA_W];
            end
        end
    end

    assign ec_spent   = ec & data[EC_BITS-1:0];
    assign spends_bit = |(ec & ~data[EC_BITS-1:0]);
    assign in_order   = (seq != SQ_IDLE) && (pos != '0) && (addr == pos);

    always_comb begin
        wr_stb   = 1'b0;
        wr_data  = data;
        v_fail   = 1'b0;
        v_state  = SQ_IDLE;
        v_pos    = '0;
        v_unlock = 1'b0;
        run_len  = LW'(REJ_CYCLES);
        if (op == OP_UPDATE) begin
            if (unlocked) begin
                wr_stb  = 1'b1;
                run_len = LW'(UPD_CYCLES);
            end else if (addr == '0 && spends_bit) begin
                // spend: only 1 -> 0 transitions reach the counter
                wr_stb               = 1'b1;
                wr_data              = '0;
                wr_data[EC_BITS-1:0] = ec_spent;
                run_len              = LW'(UPD_CYCLES);
                v_state              = SQ_ARMED;
                v_pos                = AW'(1);
            end else begin
                v_fail = 1'b1;
            end
        end else begin
            run_len = LW'(CMP_CYCLES);
            if (in_order && data == expect_byte) begin
                if (pos == AW'(CODE_BYTES)) begin
                    v_unlock = 1'b1;
                end else begin
                    v_state = SQ_PART;
                    v_pos   = pos + AW'(1);
                end
            end else begin
                v_fail = 1'b1;
            end
        end
    end

endmodule

// File: rtl/sec_seq_fsm.sv
module sec_seq_fsm
    import sec_unlock_pkg::*;
#(
    parameter int AW = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          brk,
    input  logic          commit,
    input  seq_e          c_state,
    input  logic [AW-1:0] c_pos,
    input  logic          c_unlock,
    output seq_e          seq,
    output logic [AW-1:0] pos,
    output logic          unlocked
);

    seq_e          state_q, state_d;
    logic [AW-1:0] pos_q, pos_d;
    logic          unl_q, unl_d;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= SQ_IDLE;
            pos_q   <= '0;
            unl_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            pos_q   <= pos_d;
            unl_q   <= unl_d;
        end
    end

    // Next state: break wins over a completing command
    always_comb begin
        state_d = state_q;
        pos_d   = pos_q;
        unl_d   = unl_q;
        if (brk) begin
            state_d = SQ_IDLE;
            pos_d   = '0;
        end else if (commit) begin
            unique case (c_state)
                SQ_IDLE:  pos_d = '0;
                SQ_ARMED: pos_d = c_pos;
                SQ_PART:  pos_d = c_pos;
                default:  pos_d = '0;
            endcase
            state_d = c_state;
            if (c_unlock) begin
                unl_d = 1'b1;
            end
        end
    end

    // Outputs
    always_comb begin
        seq      = state_q;
        pos      = pos_q;
        unlocked = unl_q;
    end

endmodule

// File: rtl/sec_proc_timer.sv
module sec_proc_timer
    import sec_unlock_pkg::*;
#(
    parameter int LW = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          brk,
    input  logic          start,
    input  logic [LW-1:0] len,
    output logic          busy,
    output logic          done
);

    proc_e         state_q, state_d;
    logic [LW-1:0] cnt_q, cnt_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= PR_IDLE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        unique case (state_q)
            PR_IDLE: begin
                if (start && !brk) begin
                    state_d = PR_RUN;
                    cnt_d   = len - LW'(1);
                end
            end
            PR_RUN: begin
                if (brk || cnt_q == '0) begin
                    state_d = PR_IDLE;
                    cnt_d   = '0;
                end else begin
                    cnt_d = cnt_q - LW'(1);
                end
            end
            default: state_d = PR_IDLE;
        endcase
    end

    always_comb begin
        busy = (state_q == PR_RUN);
        done = (state_q == PR_RUN) && (cnt_q == '0);
    end

endmodule

// File: rtl/sec_unlock.sv
module sec_unlock
    import sec_unlock_pkg::*;
#(
    parameter int DATA_W     = 8,
    parameter int CODE_BYTES = 3,
    parameter int EC_BITS    = 3,
    parameter int UPD_CYCLES = 6,
    parameter int CMP_CYCLES = 2,
    parameter int REJ_CYCLES = 2,
    parameter logic [EC_BITS-1:0] INIT_EC = '1,
    parameter logic [CODE_BYTES*DATA_W-1:0] INIT_CODE = 24'hC3_5A_91
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              brk,
    input  logic              cmd_valid,
    input  logic              cmd_op,
    input  logic [1:0]        cmd_addr,
    input  logic [DATA_W-1:0] cmd_data,
    input  logic [1:0]        rd_idx,
    output logic [DATA_W-1:0] rd_data,
    output logic              busy,
    output logic              wr_en,
    output logic              fail
);

    localparam int AW      = $clog2(CODE_BYTES + 1);
    localparam int MAX_A   = (UPD_CYCLES > CMP_CYCLES) ? UPD_CYCLES : CMP_CYCLES;
    localparam int MAX_LEN = (MAX_A > REJ_CYCLES) ? MAX_A : REJ_CYCLES;
    localparam int LW      = $clog2(MAX_LEN + 1);

    logic [EC_BITS-1:0]           ec_w;
    logic [CODE_BYTES*DATA_W-1:0] code_w;
    seq_e                         seq_w;
    logic [AW-1:0]                pos_w;
    logic                         unl_w;
    logic                         done_w;
    logic                         accept;

    logic                         j_wr;
    logic [DATA_W-1:0]            j_data;
    logic                         j_fail;
    seq_e                         j_state;
    logic [AW-1:0]                j_pos;
    logic                         j_unlock;
    logic [LW-1:0]                j_len;

    logic                         pend_fail;
    seq_e                         pend_state;
    logic [AW-1:0]                pend_pos;
    logic                         pend_unlock;

    assign accept = cmd_valid && !busy && !brk;

    sec_judge #(
        .DATA_W(DATA_W), .CODE_BYTES(CODE_BYTES), .EC_BITS(EC_BITS), .AW(AW), .LW(LW),
        .UPD_CYCLES(UPD_CYCLES), .CMP_CYCLES(CMP_CYCLES), .REJ_CYCLES(REJ_CYCLES)
    ) u_judge (
        .op(cmd_op), .addr(AW'(cmd_addr)), .data(cmd_data), .ec(ec_w), .code(code_w),
        .seq(seq_w), .pos(pos_w), .unlocked(unl_w),
        .wr_stb(j_wr), .wr_data(j_data), .v_fail(j_fail), .v_state(j_state),
        .v_pos(j_pos), .v_unlock(j_unlock), .run_len(j_len)
    );

    sec_store #(
        .DATA_W(DATA_W), .CODE_BYTES(CODE_BYTES), .EC_BITS(EC_BITS), .AW(AW),
        .INIT_EC(INIT_EC), .INIT_CODE(INIT_CODE)
    ) u_store (
        .clk(clk), .rst_n(rst_n), .wr_stb(accept && j_wr), .wr_addr(AW'(cmd_addr)),
        .wr_data(j_data), .unlocked(unl_w), .rd_idx(AW'(rd_idx)), .rd_data(rd_data),
        .ec_o(ec_w), .code_o(code_w)
    );

    sec_proc_timer #(.LW(LW)) u_timer (
        .clk(clk), .rst_n(rst_n), .brk(brk), .start(accept), .len(j_len),
        .busy(busy), .done(done_w)
    );

    // Verdict held until the command completes
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pend_fail   <= 1'b0;
            pend_state  <= SQ_IDLE;
            pend_pos    <= '0;
            pend_unlock <= 1'b0;
        end else if (accept) begin
            pend_fail   <= j_fail;
            pend_state  <= j_state;
            pend_pos    <= j_pos;
            pend_unlock <= j_unlock;
        end
    end

    sec_seq_fsm #(.AW(AW)) u_seq (
        .clk(clk), .rst_n(rst_n), .brk(brk), .commit(done_w),
        .c_state(pend_state), .c_pos(pend_pos), .c_unlock(pend_unlock),
        .seq(seq_w), .pos(pos_w), .unlocked(unl_w)
    );

    assign wr_en = unl_w;
    assign fail  = done_w && pend_fail;

endmodule

// File: rtl/sec_unlock_chk.sv
module sec_unlock_chk #(
    parameter int DATA_W     = 8,
    parameter int CODE_BYTES = 3,
    parameter int EC_BITS    = 3,
    parameter int RUN_MAX    = 8
) (
    input logic                         clk,
    input logic                         rst_n,
    input logic                         busy,
    input logic                         wr_en,
    input logic                         fail,
    input logic [1:0]                   rd_idx,
    input logic [DATA_W-1:0]            rd_data,
    input logic [EC_BITS-1:0]           ec,
    input logic [CODE_BYTES*DATA_W-1:0] code
);

    int busy_run;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            busy_run <= 0;
        end else if (busy) begin
            busy_run <= busy_run + 1;
        end else begin
            busy_run <= 0;
        end
    end

    // R2
    locked_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_en && rd_idx != 2'd0) |-> (rd_data == '0));

    // R2
    ec_upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_idx == 2'd0) |-> ((rd_data >> EC_BITS) == '0));

    // R12
    ec_no_regrow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> ((ec & ~$past(ec)) == '0));

    // R10
    unlock_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> wr_en);

    // R6
    open_at_finish_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wr_en) |-> $past(busy));

    // R11
    busy_store_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> ($stable(ec) && $stable(code)));

    // R7
    fail_in_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fail |-> busy);

    // R4
    release_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy_run <= RUN_MAX);

endmodule

bind sec_unlock sec_unlock_chk #(
    .DATA_W(DATA_W), .CODE_BYTES(CODE_BYTES), .EC_BITS(EC_BITS), .RUN_MAX(8)
) u_chk (
    .clk(clk), .rst_n(rst_n), .busy(busy), .wr_en(wr_en), .fail(fail),
    .rd_idx(rd_idx), .rd_data(rd_data), .ec(ec_w), .code(code_w)
);

// File: tb/sec_unlock_test.sv
module sec_unlock_test;

    localparam int CLK_PERIOD = 10;
    localparam int UPD = 6;
    localparam int CMP = 2;
    localparam int REJ = 2;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       brk = 1'b0;
    logic       cmd_valid = 1'b0;
    logic       cmd_op = 1'b0;
    logic [1:0] cmd_addr = 2'd0;
    logic [7:0] cmd_data = 8'd0;
    logic [1:0] rd_idx = 2'd0;
    logic [7:0] rd_data;
    logic       busy, wr_en, fail;

    int checks = 0;
    int errors = 0;
    bit done_flag = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    sec_unlock uut (
        .clk(clk), .rst_n(rst_n), .brk(brk), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
        .cmd_addr(cmd_addr), .cmd_data(cmd_data), .rd_idx(rd_idx), .rd_data(rd_data),
        .busy(busy), .wr_en(wr_en), .fail(fail)
    );

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    // ---------------- behavioural reference model ----------------
    int m_ec;
    int m_code[1:3];
    int m_unl, m_seq, m_left, m_pfail, m_pseq, m_punl;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_ec = 7; m_code[1] = 'h91; m_code[2] = 'h5A; m_code[3] = 'hC3;
            m_unl = 0; m_seq = 0; m_left = 0; m_pfail = 0; m_pseq = 0; m_punl = 0;
        end else if (brk) begin
            m_left = 0; m_seq = 0;
        end else if (m_left > 0) begin
            m_left--;
            if (m_left == 0) begin
                m_seq = m_pseq;
                if (m_punl != 0) m_unl = 1;
            end
        end else if (cmd_valid) begin
            m_pfail = 0; m_pseq = 0; m_punl = 0;
            if (cmd_op == 1'b0) begin
                if (m_unl != 0) begin
                    if (cmd_addr == 0) m_ec = cmd_data & 7;
                    else m_code[cmd_addr] = cmd_data;
                    m_left = UPD;
                end else if (cmd_addr == 0 && ((m_ec & ~cmd_data & 7) != 0)) begin
                    m_ec = m_ec & cmd_data;
                    m_left = UPD; m_pseq = 1;
                end else begin
                    m_left = REJ; m_pfail = 1;
                end
            end else begin
                m_left = CMP;
                if (m_seq != 0 && cmd_addr == m_seq && cmd_data == m_code[cmd_addr]) begin
                    if (m_seq == 3) m_punl = 1;
                    else m_pseq = m_seq + 1;
                end else begin
                    m_pfail = 1;
                end
            end
        end
    end

    // Compared every clock, a quarter period after the edge
    always @(posedge clk) begin
        #(CLK_PERIOD/4);
        if (rst_n && !done_flag) begin
            chk("R5 busy", busy, (m_left > 0) ? 1 : 0);
            chk("R6 wr_en", wr_en, m_unl);
            chk("R7 fail", fail, (m_left == 1 && m_pfail != 0) ? 1 : 0);
            chk("R2 rd_data", rd_data,
                (rd_idx == 0) ? m_ec : ((m_unl != 0) ? m_code[rd_idx] : 0));
        end
    end

    // ---------------- stimulus tasks ----------------
    task automatic do_reset();
        @(negedge clk); rst_n = 0;
        @(negedge clk); @(negedge clk); rst_n = 1;
    endtask

    task automatic issue(input logic op, input logic [1:0] a, input logic [7:0] d,
                         output int len, output bit sawf);
        @(negedge clk);
        cmd_valid = 1; cmd_op = op; cmd_addr = a; cmd_data = d; rd_idx = rd_idx + 1;
        @(negedge clk);
        cmd_valid = 0; len = 0; sawf = 0;
        while (busy) begin
            if (fail) sawf = 1;
            len++;
            @(negedge clk);
            rd_idx = rd_idx + 1;
        end
    endtask

    task automatic peek(input logic [1:0] idx, input int exp, input string tag);
        @(negedge clk); rd_idx = idx; #1;
        chk(tag, rd_data, exp);
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        errors++;
        $display("FAIL watchdog: actual hung expected finish");
        done_flag = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        int len;
        bit f;
        do_reset();
        // R1 reset state
        peek(2'd0, 'h07, "R1 counter");
        chk("R1 wr_en", wr_en, 0);
        chk("R1 busy", busy, 0);
        // R2 locked masking
        peek(2'd1, 0, "R2 mask1");
        peek(2'd3, 0, "R2 mask3");
        // R4 refused locked update of a code slot
        issue(1'b0, 2'd2, 8'h00, len, f);
        chk("R4 len", len, REJ); chk("R4 fail", f, 1);
        // R7 compare with no spend
        issue(1'b1, 2'd1, 8'h91, len, f);
        chk("R7 nospend", f, 1);
        chk("R5 cmp len", len, CMP);
        // R3 spend one bit
        issue(1'b0, 2'd0, 8'hFE, len, f);
        chk("R3 len", len, UPD); chk("R3 nofail", f, 0);
        peek(2'd0, 'h06, "R3 counter");
        // R12 locked 0xFF cannot restore bits
        issue(1'b0, 2'd0, 8'hFF, len, f);
        chk("R12 refused", f, 1);
        peek(2'd0, 'h06, "R12 counter");
        // R7 out of order, then correct byte without new spend
        issue(1'b0, 2'd0, 8'hFD, len, f);
        issue(1'b1, 2'd2, 8'h5A, len, f);
        chk("R7 order", f, 1);
        issue(1'b1, 2'd1, 8'h91, len, f);
        chk("R7 voided", f, 1);
        chk("R7 locked", wr_en, 0);

        // Phase B: break, then success
        do_reset();
        issue(1'b0, 2'd0, 8'hFE, len, f);
        issue(1'b1, 2'd1, 8'h91, len, f);
        issue(1'b1, 2'd2, 8'h5A, len, f);
        @(negedge clk);
        cmd_valid = 1; cmd_op = 1; cmd_addr = 2'd3; cmd_data = 8'hC3;
        @(negedge clk); cmd_valid = 0; brk = 1;
        @(negedge clk); brk = 0;
        chk("R10 busy", busy, 0);
        chk("R10 locked", wr_en, 0);
        issue(1'b1, 2'd3, 8'hC3, len, f);
        chk("R10 tracker", f, 1);
        issue(1'b0, 2'd0, 8'hFD, len, f);
        issue(1'b1, 2'd1, 8'h91, len, f);
        issue(1'b1, 2'd2, 8'h5A, len, f);
        issue(1'b1, 2'd3, 8'hC3, len, f);
        chk("R6 open", wr_en, 1); chk("R6 nofail", f, 0);
        peek(2'd2, 'h5A, "R2 open read");
        // R9 rewrites
        issue(1'b0, 2'd0, 8'hFF, len, f);
        peek(2'd0, 'h07, "R9 restore");
        issue(1'b0, 2'd2, 8'h33, len, f);
        peek(2'd2, 'h33, "R9 code write");
        @(negedge clk); brk = 1;
        @(negedge clk); brk = 0;
        chk("R10 stays open", wr_en, 1);
        // R11 valid during busy ignored
        @(negedge clk);
        cmd_valid = 1; cmd_op = 0; cmd_addr = 2'd1; cmd_data = 8'h44;
        @(negedge clk); cmd_addr = 2'd3; cmd_data = 8'h55;
        @(negedge clk); @(negedge clk); cmd_valid = 0;
        while (busy) @(negedge clk);
        peek(2'd3, 'hC3, "R11 ignored");
        peek(2'd1, 'h44, "R11 accepted");

        // Phase C: exhaust counter
        do_reset();
        issue(1'b0, 2'd0, 8'h00, len, f);
        peek(2'd0, 0, "R8 counter zero");
        issue(1'b1, 2'd1, 8'h00, len, f);
        issue(1'b0, 2'd0, 8'h00, len, f);
        chk("R8 refused", f, 1);
        issue(1'b0, 2'd0, 8'hFF, len, f);
        chk("R8 refused ff", f, 1);
        peek(2'd0, 0, "R8 still zero");
        chk("R8 locked", wr_en, 0);

        repeat (3) @(negedge clk);
        done_flag = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule